// File: doc/BRIEF.md
# Bus Master Burst Termination Controller

This block sits beside the initiator state machine of a PCI-style bus master and makes one decision on every data phase of a burst: hold initiator-ready low to stretch the phase with wait states, complete the phase and continue, or complete the phase as the final one and let the bus go idle. The decision draws on four sources. The data buffer reports whether the following phase is ready. A programmable access counter can cap the burst length. Software can ask for termination. The bus side reports time-out or end of data.

A burst begins with a one-cycle `start` pulse while the block is idle. The value on `cnt_load` is captured at that moment. A data phase completes on any cycle where `irdy` and `tgt_rdy` are both high. When that phase also carries `last_phase`, the block reports idle on the following cycle. Every ending caused this way is an ordinary master-initiated completion and never an abort.

Top module: `mburst_term_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, `bus_idle` is 1 and `irdy` and `last_phase` are 0. While idle, `irdy` and `last_phase` remain 0.
- R2: A `start` pulse while idle makes `bus_idle` drop to 0 on the next cycle. `start` has no effect during a burst.
- R3: When wait states are allowed, the next phase is not ready, and no end cause is present, `irdy` is 0. This stretches the current phase.
- R4: When the next phase is ready and no end cause is present, `irdy` is 1 and `last_phase` is 0.
- R5: When wait-state disable is set in bus-master mode and the next phase is not ready, `irdy` and `last_phase` are both 1. The phase completes without a stall and ends the burst.
- R6: When the counter is enabled in bus-master mode with load value L, the burst completes exactly L+1 data phases. The last of these carries `last_phase`, even if the next phase is ready.
- R7: When the counter is disabled, the burst keeps going past the loaded count for as long as no software request, time-out or end-of-data arrives.
- R8: A one-cycle `sw_term` pulse during a burst is held. From that cycle until the burst ends, `irdy` and `last_phase` are both 1.
- R9: A `timeout` during a burst sets `irdy` and `last_phase` to 1.
- R10: `data_last` during a burst sets `irdy` and `last_phase` to 1.
- R11: When `master_mode` is 0, `nowait_en` and `cnt_en` have no effect. The block stalls on a not-ready next phase, and burst length is unlimited.
- R12: A completed phase with `last_phase` high gives `bus_idle` = 1 on the next cycle. A completed phase without it keeps the burst going.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | Interface is acting as bus master |
| nowait_en | input | 1 | Disable wait-state insertion |
| cnt_en | input | 1 | Enable the access counter cutoff |
| cnt_load | input | CNT_W | Remaining phases after the first, captured at start |
| start | input | 1 | Begin a burst (pulse, honoured only when idle) |
| sw_term | input | 1 | Software terminate request (pulse) |
| next_ok | input | 1 | Following data phase can be completed |
| timeout | input | 1 | Bus time-out, end the burst |
| data_last | input | 1 | No further data, end the burst |
| tgt_rdy | input | 1 | Target ready; phase completes when high with irdy |
| irdy | output | 1 | Initiator ready |
| last_phase | output | 1 | Current phase is the final one |
| bus_idle | output | 1 | No burst in progress |

## Verification
Bursts are run with the next phase ready and with it withheld. Each is run with wait states allowed and with them disabled, which separates a stall from a termination. Counter bursts with several load values, including zero, are repeated with the counter off and with master mode off. This shows that the cutoff comes only from the enabled counter, and that both controls have no effect outside master mode. Software pulses given during a stall, time-outs and end-of-data each end a burst. A target that holds `tgt_rdy` low shows that the held request and the count survive an uncompleted phase.

// File: rtl/mbt_pkg.sv
// Package: shared types for the burst termination controller.
// Assumes: single clock domain.
package mbt_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } mbt_state_e;

    // Reasons that the current phase must be the final one.
    typedef struct packed {
        logic sw;
        logic tmo;
        logic fin;
        logic tc;
    } mbt_cause_t;
endpackage

// File: rtl/mbt_access_cnt.sv
// Module: access counter. Loads the remaining-phase count at burst start,
// counts down once per completed phase, saturates at zero, and flags
// terminal count when zero is reached.
// Assumes: load and dec are never high in the same cycle.
module mbt_access_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, step down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != ZERO)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Terminal count flag.
    always_comb tc = (cnt_q == ZERO);

    AST_CNT_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val == ZERO)) |=> tc); // R6
endmodule

// File: rtl/mbt_term_req.sv
// Module: holds a software terminate request from its pulse until the
// burst returns to idle. Software has no way to withdraw it.
// Assumes: sw_term is a one-cycle pulse; it is ignored while idle.
module mbt_term_req (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic sw_term,
    output logic pend
);
    logic req_q;

    // Sticky request, cleared only by the hardware at idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            req_q <= 1'b0;
        end else if (sw_term) begin
            req_q <= 1'b1;
        end
    end

    // The request takes effect in the cycle of the pulse itself.
    always_comb pend = busy && (sw_term || req_q);

    AST_SW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sw_term) |=> (pend || !busy)); // R8
endmodule

// File: rtl/mbt_phase_ctl.sv
// Module: per-phase decision and burst state. Gates the mode-dependent
// controls, gathers the end causes, drives irdy/last and returns to idle
// after a final phase completes.
// Assumes: tc and sw_pend come from the counter and request holder.
module mbt_phase_ctl
    import mbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic nowait_en,
    input  logic cnt_en,
    input  logic start,
    input  logic next_ok,
    input  logic timeout,
    input  logic data_last,
    input  logic tgt_rdy,
    input  logic tc,
    input  logic sw_pend,
    output logic irdy,
    output logic last_phase,
    output logic bus_idle,
    output logic cnt_load_en,
    output logic cnt_dec
);
    mbt_state_e state_q;
    mbt_cause_t cause;
    logic       busy;
    logic       nowait_eff;
    logic       cnt_eff;
    logic       end_now;
    logic       phase_done;

    // The two controls only apply in bus-master mode.
    always_comb begin
        nowait_eff = master_mode && nowait_en;
        cnt_eff    = master_mode && cnt_en;
    end

    // Collect end causes and make the phase decision.
    always_comb begin
        busy       = (state_q == ST_BURST);
        cause.sw   = sw_pend;
        cause.tmo  = busy && timeout;
        cause.fin  = busy && data_last;
        cause.tc   = busy && cnt_eff && tc;
        end_now    = |cause;
        irdy       = busy && (end_now || next_ok || nowait_eff);
        last_phase = busy && (end_now || (nowait_eff && !next_ok));
        phase_done = irdy && tgt_rdy;
        bus_idle   = !busy;
    end

    // Counter controls.
    always_comb begin
        cnt_load_en = !busy && start;
        cnt_dec     = phase_done && !last_phase;
    end

    // Burst state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!busy && start) begin
            state_q <= ST_BURST;
        end else if (phase_done && last_phase) begin
            state_q <= ST_IDLE;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> (!irdy && !last_phase)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && start) |=> !bus_idle); // R2
    AST_NOWAIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && master_mode && nowait_en) |-> irdy); // R5
    AST_TC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && master_mode && cnt_en && tc) |-> last_phase); // R6
    AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && timeout) |-> (irdy && last_phase)); // R9
    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy && tgt_rdy && last_phase) |=> bus_idle); // R12
endmodule

// File: rtl/mburst_term_ctrl.sv
// Module: top of the bus master burst termination controller. Connects
// the phase decision, the access counter and the software request holder.
// Assumes: synchronous active-low reset, a single clock.
module mburst_term_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_mode,
    input  logic             nowait_en,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_load,
    input  logic             start,
    input  logic             sw_term,
    input  logic             next_ok,
    input  logic             timeout,
    input  logic             data_last,
    input  logic             tgt_rdy,
    output logic             irdy,
    output logic             last_phase,
    output logic             bus_idle
);
    logic tc;
    logic sw_pend;
    logic load_en;
    logic dec_en;
    logic busy;

    always_comb busy = !bus_idle;

    mbt_access_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (cnt_load),
        .dec      (dec_en),
        .tc       (tc)
    );

    mbt_term_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .sw_term (sw_term),
        .pend    (sw_pend)
    );

    mbt_phase_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .nowait_en   (nowait_en),
        .cnt_en      (cnt_en),
        .start       (start),
        .next_ok     (next_ok),
        .timeout     (timeout),
        .data_last   (data_last),
        .tgt_rdy     (tgt_rdy),
        .tc          (tc),
        .sw_pend     (sw_pend),
        .irdy        (irdy),
        .last_phase  (last_phase),
        .bus_idle    (bus_idle),
        .cnt_load_en (load_en),
        .cnt_dec     (dec_en)
    );
endmodule

// File: tb/mburst_term_ctrl_test.sv
module mburst_term_ctrl_test;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b0, nowait_en = 1'b0, cnt_en = 1'b0;
    logic [CNT_W-1:0] cnt_load = '0;
    logic start = 1'b0, sw_term = 1'b0, next_ok = 1'b0;
    logic timeout = 1'b0, data_last = 1'b0, tgt_rdy = 1'b0;
    logic irdy, last_phase, bus_idle;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state.
    bit m_busy = 1'b0;
    int m_left = 0;
    bit m_pend = 1'b0;
    int phases = 0;

    mburst_term_ctrl #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .nowait_en(nowait_en), .cnt_en(cnt_en), .cnt_load(cnt_load),
        .start(start), .sw_term(sw_term), .next_ok(next_ok),
        .timeout(timeout), .data_last(data_last), .tgt_rdy(tgt_rdy),
        .irdy(irdy), .last_phase(last_phase), .bus_idle(bus_idle)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {irdy,last,idle} actual=%b expected=%b at cycle %0d",
                     req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Every cycle: compare against the model, then advance the model.
    always @(negedge clk) begin
        bit e_irdy, e_last, tc_hit, pend_now, endc;
        string req;
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1'b1;
            finish_run();
        end
        pend_now = m_busy && (m_pend || sw_term);
        tc_hit   = m_busy && master_mode && cnt_en && (m_left == 0);
        endc     = pend_now || (m_busy && (timeout || data_last)) || tc_hit;
        e_irdy   = m_busy && (endc || next_ok || (master_mode && nowait_en));
        e_last   = m_busy && (endc || (master_mode && nowait_en && !next_ok));
        if (!m_busy)                 req = "R1";
        else if (pend_now)           req = "R8";
        else if (timeout)            req = "R9";
        else if (data_last)          req = "R10";
        else if (tc_hit)             req = "R6";
        else if (!master_mode)       req = "R11";
        else if (nowait_en && !next_ok) req = "R5";
        else if (next_ok)            req = "R4";
        else                         req = "R3";
        if (armed) check(req, {irdy, last_phase, bus_idle}, {e_irdy, e_last, !m_busy});
        if (!rst_n) begin
            m_busy = 1'b0; m_left = 0; m_pend = 1'b0;
        end else if (!m_busy) begin
            if (start) begin m_busy = 1'b1; m_left = int'(cnt_load); m_pend = 1'b0; phases = 0; end
        end else begin
            if (sw_term) m_pend = 1'b1;
            if (e_irdy && tgt_rdy) begin
                phases++;
                if (e_last) begin m_busy = 1'b0; m_pend = 1'b0; end
                else if (m_left > 0) m_left--;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        start = 1'b0; sw_term = 1'b0;
    endtask

    task automatic begin_burst(input int load);
        cnt_load = CNT_W'(load);
        start = 1'b1;
        step();
    endtask

    // Wait for the burst to end (bounded).
    task automatic run_to_idle(input int limit);
        for (int i = 0; i < limit && !bus_idle; i++) step();
    endtask

    initial begin
        step(); armed = 1'b1; step();
        rst_n = 1'b1; step();
        check("R1", {irdy, last_phase, bus_idle}, 3'b001);

        // R2, R4, R6: counter burst with data always ready, L=3.
        master_mode = 1; cnt_en = 1; next_ok = 1; tgt_rdy = 1;
        begin_burst(3);
        check("R2", {1'b0, 1'b0, bus_idle}, 3'b000);
        run_to_idle(20);
        checks++; if (phases != 4) begin errors++; $display("FAIL R6: phases actual=%0d expected=4", phases); end
        // R6 with L=0: one phase.
        begin_burst(0); run_to_idle(20);
        checks++; if (phases != 1) begin errors++; $display("FAIL R6: phases actual=%0d expected=1", phases); end
        // R6 with a slow target: count survives uncompleted phases.
        begin_burst(2);
        for (int i = 0; i < 12; i++) begin tgt_rdy = (i % 3 == 2); step(); end
        tgt_rdy = 1; run_to_idle(20);
        checks++; if (phases != 3) begin errors++; $display("FAIL R6: phases actual=%0d expected=3", phases); end

        // R7: counter off, long burst, ended by data_last (R10).
        cnt_en = 0; begin_burst(1);
        for (int i = 0; i < 10; i++) step();
        checks++; if (bus_idle !== 1'b0) begin errors++; $display("FAIL R7: idle actual=%b expected=0", bus_idle); end
        data_last = 1; step(); data_last = 0; step();
        check("R10", {irdy, last_phase, bus_idle}, 3'b001);

        // R3 stall, then R8 pulse during stall held while target waits.
        next_ok = 0; begin_burst(5);
        for (int i = 0; i < 4; i++) step();
        tgt_rdy = 0; sw_term = 1; step();
        step(); step();
        tgt_rdy = 1; run_to_idle(5);
        check("R8", {irdy, last_phase, bus_idle}, 3'b001);

        // R9: timeout during stall.
        begin_burst(5); step(); step();
        timeout = 1; step(); timeout = 0; step();

        // R5: no-wait mode ends on first not-ready phase.
        nowait_en = 1; next_ok = 1; begin_burst(5);
        step(); step(); next_ok = 0; step(); step();
        check("R5", {irdy, last_phase, bus_idle}, 3'b001);

        // R11: outside master mode, no-wait and counter ignored.
        master_mode = 0; cnt_en = 1; next_ok = 0; begin_burst(0);
        for (int i = 0; i < 6; i++) step();
        next_ok = 1;
        for (int i = 0; i < 6; i++) step();
        check("R11", {1'b0, 1'b0, bus_idle}, 3'b000);
        timeout = 1; step(); timeout = 0; step();

        // R12: start during a burst ignored; data_last completes.
        master_mode = 1; nowait_en = 0; cnt_en = 0; next_ok = 1;
        begin_burst(0); cnt_load = 0; start = 1; step(); step();
        data_last = 1; tgt_rdy = 0; step(); step();
        check("R12", {1'b0, 1'b0, bus_idle}, 3'b000);
        tgt_rdy = 1; step(); data_last = 0; step();
        check("R12", {irdy, last_phase, bus_idle}, 3'b001);

        // R1: reset in mid-burst.
        begin_burst(7); step(); rst_n = 0; step(); step();
        check("R1", {irdy, last_phase, bus_idle}, 3'b001);
        rst_n = 1; step(); step();
        done = 1'b1;
        finish_run();
    end
endmodule